// File: doc/BRIEF.md
# Exception Entry and Return State Unit

This unit holds the live processor status word together with one saved-status register and one return-address register for each of privilege levels 1, 2 and 3. Level 0 has no saved state, because no exception is ever taken to it. An exception-entry pulse saves the live status and a return address into the bank of the target level. It then raises the live level to that target, sets every interrupt mask and selects the level's own stack. An exception-return pulse copies the saved status of the current level back into the live word, including its level field, and presents the saved return address.

The same unit gates software access. A system-register port reads or writes the saved status and return address of a chosen level, and it is granted only when the current level is at least that level. The condition flags may be written at any level. The interrupt masks and the stack-select bit need level 1 or higher. Any refused operation raises a one-cycle illegal pulse and changes no state. Only one operation is acted on per cycle. The priority, from highest to lowest, is entry, return, system-register access, then status-field writes.

Top module: `exc_state_unit`

## Requirements
- R1: After reset the status word is {flags 0000, masks 1111, level 3, stack-select 1}, and the return-valid, illegal and access-acknowledge pulses are low. The status bit layout is flags N,Z,C,V in bits 10:7, masks D,A,I,F in bits 6:3, level in bits 2:1 and stack-select in bit 0.
- R2: An entry request to a target level that is not 0 and not below the current level changes the status one cycle later. The level becomes the target, all four masks are set, stack-select becomes 1 and the flags are kept. The status held before the entry is stored as the target level's saved status.
- R3: On a legal entry the supplied return address is stored in the target level's return-address register. A later return from that level presents it.
- R4: A return request at level 1 or higher loads the saved status of the current level into the live status one cycle later. In that same cycle it drives the saved return address and a single-cycle return-valid pulse.
- R5: An entry request to level 0, or to a level below the current one, raises the illegal pulse one cycle later and leaves all state unchanged.
- R6: A return request at level 0 raises the illegal pulse, gives no return-valid pulse and leaves all state unchanged.
- R7: A flag write replaces N,Z,C,V one cycle later at any level.
- R8: A mask write replaces D,A,I,F and stack-select (data bits 4:1 and 0) one cycle later when the level is 1 or higher. At level 0 it raises the illegal pulse and changes nothing.
- R9: A system-register access to the saved bank of level m (1 to 3) is acknowledged one cycle later only if the current level is at least m. A write stores the given status and address. A read returns them. Otherwise, and for m = 0, the illegal pulse is raised and nothing is stored.
- R10: When entry and return are requested in the same cycle, only the entry is acted on.
- R11: An entry or a return in a cycle drops any system-register access or status-field write in that cycle, without raising the illegal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Exception-entry pulse |
| entry_level | input | 2 | Target level of the entry |
| entry_addr | input | ADDR_W | Return address to save on entry |
| eret_req | input | 1 | Exception-return pulse |
| sr_req | input | 1 | System-register access request |
| sr_we | input | 1 | 1 = write, 0 = read |
| sr_lvl | input | 2 | Level whose saved bank is accessed |
| sr_wstatus | input | 11 | Status value to write |
| sr_waddr | input | ADDR_W | Return address to write |
| flag_wr | input | 1 | Write the condition flags |
| flag_data | input | 4 | New N,Z,C,V |
| ctl_wr | input | 1 | Write masks and stack-select |
| ctl_data | input | 5 | New D,A,I,F (4:1) and stack-select (0) |
| status_o | output | 11 | Live status word |
| ret_valid_o | output | 1 | Return-address valid pulse |
| ret_addr_o | output | ADDR_W | Return address of the last return |
| illegal_o | output | 1 | Refused-operation pulse |
| sr_ack_o | output | 1 | Access acknowledge pulse |
| sr_rstatus_o | output | 11 | Saved status read back |
| sr_raddr_o | output | ADDR_W | Return address read back |

## Verification
Every result is due exactly one clock edge after its request. This covers the new status word, the return-valid, illegal and acknowledge pulses, and the read-back data. The bench drives each request on a falling edge and compares the outputs on the next falling edge, so exactly one rising edge lies between stimulus and sample. A table walk then chains requests so that values saved by one entry are observed through later reads and returns. This confirms that state left untouched by refused or dropped operations is still intact.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int LVL_W = 2;

  typedef struct packed {
    logic [3:0]       nzcv;
    logic [3:0]       daif;
    logic [LVL_W-1:0] lvl;
    logic             sp_sel;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
  localparam status_t STATUS_RST = '{nzcv: 4'h0, daif: 4'hF, lvl: 2'd3, sp_sel: 1'b1};
endpackage

// File: rtl/exc_priv_check.sv
module exc_priv_check #(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] have_lvl,
  input  logic [LVL_W-1:0] need_lvl,
  output logic             ok
);
  assign ok = (have_lvl >= need_lvl);
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int DW    = 43,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LVL_W-1:0] wlvl,
  input  logic [DW-1:0]    wdata,
  input  logic [LVL_W-1:0] rlvl,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = (1 << LVL_W) - 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [LVL_W-1:0] widx, ridx;

  assign widx = (wlvl == '0) ? '0 : wlvl - 1'b1;
  assign ridx = (rlvl == '0) ? '0 : rlvl - 1'b1;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                entry_req,
  input  logic [LVL_W-1:0]    entry_level,
  input  logic [ADDR_W-1:0]   entry_addr,
  input  logic                eret_req,
  input  logic                sr_req,
  input  logic                sr_we,
  input  logic [LVL_W-1:0]    sr_lvl,
  input  logic [STATUS_W-1:0] sr_wstatus,
  input  logic [ADDR_W-1:0]   sr_waddr,
  input  logic                flag_wr,
  input  logic [3:0]          flag_data,
  input  logic                ctl_wr,
  input  logic [4:0]          ctl_data,
  output logic [STATUS_W-1:0] status_o,
  output logic                ret_valid_o,
  output logic [ADDR_W-1:0]   ret_addr_o,
  output logic                illegal_o,
  output logic                sr_ack_o,
  output logic [STATUS_W-1:0] sr_rstatus_o,
  output logic [ADDR_W-1:0]   sr_raddr_o
);
  localparam int BANK_W = STATUS_W + ADDR_W;
  localparam logic [LVL_W-1:0] LVL_ONE = 1;

  status_t          st_q;
  logic             entry_up_ok, eret_ok, sr_ok, ctl_ok, sr_priv;
  logic             bank_we;
  logic [LVL_W-1:0] bank_wlvl, bank_rlvl;
  logic [BANK_W-1:0] bank_wdata, bank_rdata;
  status_t          rd_status;
  logic [ADDR_W-1:0] rd_addr;

  // target must not be below the current level
  exc_priv_check #(.LVL_W(LVL_W)) u_entry_chk (
    .have_lvl(entry_level), .need_lvl(st_q.lvl), .ok(entry_up_ok));
  exc_priv_check #(.LVL_W(LVL_W)) u_eret_chk (
    .have_lvl(st_q.lvl), .need_lvl(LVL_ONE), .ok(eret_ok));
  exc_priv_check #(.LVL_W(LVL_W)) u_sr_chk (
    .have_lvl(st_q.lvl), .need_lvl(sr_lvl), .ok(sr_priv));
  exc_priv_check #(.LVL_W(LVL_W)) u_ctl_chk (
    .have_lvl(st_q.lvl), .need_lvl(LVL_ONE), .ok(ctl_ok));

  logic entry_ok;
  assign entry_ok = entry_up_ok && (entry_level != '0);
  assign sr_ok    = sr_priv && (sr_lvl != '0);

  always_comb begin
    bank_we    = 1'b0;
    bank_wlvl  = sr_lvl;
    bank_wdata = {sr_wstatus, sr_waddr};
    if (entry_req) begin
      bank_we    = entry_ok;
      bank_wlvl  = entry_level;
      bank_wdata = {st_q, entry_addr};
    end else if (!eret_req && sr_req) begin
      bank_we    = sr_ok && sr_we;
    end
  end

  assign bank_rlvl = eret_req ? st_q.lvl : sr_lvl;

  exc_save_bank #(.DW(BANK_W), .LVL_W(LVL_W)) u_bank (
    .clk(clk), .we(bank_we), .wlvl(bank_wlvl), .wdata(bank_wdata),
    .rlvl(bank_rlvl), .rdata(bank_rdata));

  assign rd_status = status_t'(bank_rdata[BANK_W-1:ADDR_W]);
  assign rd_addr   = bank_rdata[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= STATUS_RST;
      ret_valid_o  <= 1'b0;
      ret_addr_o   <= '0;
      illegal_o    <= 1'b0;
      sr_ack_o     <= 1'b0;
      sr_rstatus_o <= '0;
      sr_raddr_o   <= '0;
    end else begin
      ret_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      sr_ack_o    <= 1'b0;
      if (entry_req) begin
        if (entry_ok) begin
          st_q.lvl    <= entry_level;
          st_q.daif   <= 4'hF;
          st_q.sp_sel <= 1'b1;
        end else begin
          illegal_o <= 1'b1;
        end
      end else if (eret_req) begin
        if (eret_ok) begin
          st_q        <= rd_status;
          ret_addr_o  <= rd_addr;
          ret_valid_o <= 1'b1;
        end else begin
          illegal_o <= 1'b1;
        end
      end else if (sr_req) begin
        if (sr_ok) begin
          sr_ack_o <= 1'b1;
          if (!sr_we) begin
            sr_rstatus_o <= rd_status;
            sr_raddr_o   <= rd_addr;
          end
        end else begin
          illegal_o <= 1'b1;
        end
      end else if (flag_wr || ctl_wr) begin
        if (ctl_wr && !ctl_ok) begin
          illegal_o <= 1'b1;
        end else begin
          if (flag_wr) st_q.nzcv <= flag_data;
          if (ctl_wr) begin
            st_q.daif   <= ctl_data[4:1];
            st_q.sp_sel <= ctl_data[0];
          end
        end
      end
    end
  end

  assign status_o = st_q;

  // R2: legal entry lands on the target level with every mask set
  p_entry_target_r2: assert property (@(posedge clk) disable iff (rst)
    (entry_req && entry_level != '0 && entry_level >= status_o[2:1])
    |=> (status_o[2:1] == $past(entry_level)) && (status_o[6:3] == 4'hF)
        && (status_o[10:7] == $past(status_o[10:7])));

  // R5: bad target is refused with no state change
  p_bad_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (entry_req && (entry_level == '0 || entry_level < status_o[2:1]))
    |=> illegal_o && $stable(status_o) && !ret_valid_o);

  // R4: return above level 0 always yields a return-valid pulse
  p_eret_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (eret_req && !entry_req && status_o[2:1] != '0) |=> ret_valid_o && !illegal_o);

  // R6: return at level 0 is refused
  p_eret_lvl0_r6: assert property (@(posedge clk) disable iff (rst)
    (eret_req && !entry_req && status_o[2:1] == '0)
    |=> illegal_o && !ret_valid_o && $stable(status_o));

  // R9: acknowledged access had enough privilege
  p_ack_priv_r9: assert property (@(posedge clk) disable iff (rst)
    sr_ack_o |-> ($past(status_o[2:1]) >= $past(sr_lvl)) && ($past(sr_lvl) != '0));

  // R11: one operation per cycle, so pulses never overlap
  p_one_op_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({ret_valid_o, sr_ack_o, illegal_o}) <= 1);
endmodule

// File: tb/exc_state_unit_tb_top.sv
`timescale 1ns/1ps
module exc_state_unit_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst;
  logic           entry_req, eret_req, sr_req, sr_we, flag_wr, ctl_wr;
  logic [1:0]     entry_level, sr_lvl;
  logic [AW-1:0]  entry_addr, sr_waddr;
  logic [10:0]    sr_wstatus;
  logic [3:0]     flag_data;
  logic [4:0]     ctl_data;
  logic [10:0]    status_o, sr_rstatus_o;
  logic           ret_valid_o, illegal_o, sr_ack_o;
  logic [AW-1:0]  ret_addr_o, sr_raddr_o;

  exc_state_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .entry_req(entry_req), .entry_level(entry_level), .entry_addr(entry_addr),
    .eret_req(eret_req),
    .sr_req(sr_req), .sr_we(sr_we), .sr_lvl(sr_lvl),
    .sr_wstatus(sr_wstatus), .sr_waddr(sr_waddr),
    .flag_wr(flag_wr), .flag_data(flag_data),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .status_o(status_o), .ret_valid_o(ret_valid_o), .ret_addr_o(ret_addr_o),
    .illegal_o(illegal_o), .sr_ack_o(sr_ack_o),
    .sr_rstatus_o(sr_rstatus_o), .sr_raddr_o(sr_raddr_o));

  typedef struct packed {
    logic [7:0]  tag;
    logic        en;  logic [1:0] elvl; logic [31:0] eaddr;
    logic        er;
    logic        sq;  logic swe; logic [1:0] slvl; logic [10:0] swst; logic [31:0] swad;
    logic        fw;  logic [3:0] fd;
    logic        cw;  logic [4:0] cd;
    logic [10:0] xst; logic xrv; logic [31:0] xra;
    logic        xill; logic xack;
    logic        xrd; logic [10:0] xrst; logic [31:0] xrad;
  } vec_t;

  localparam logic [10:0] RST  = {4'h0, 4'hF, 2'd3, 1'b1};
  localparam logic [10:0] S5   = {4'h5, 4'h0, 2'd0, 1'b0};
  localparam logic [10:0] SA0  = {4'hA, 4'h0, 2'd0, 1'b0};
  localparam logic [10:0] SA1  = {4'hA, 4'hF, 2'd1, 1'b1};
  localparam logic [10:0] SA1C = {4'hA, 4'h3, 2'd1, 1'b0};
  localparam logic [10:0] S31C = {4'h3, 4'h3, 2'd1, 1'b0};
  localparam logic [10:0] S32  = {4'h3, 4'hF, 2'd2, 1'b1};
  localparam logic [10:0] SA3  = {4'hA, 4'hF, 2'd3, 1'b1};

  localparam int NV = 21;
  // tag, en,elvl,eaddr, er, sq,swe,slvl,swst,swad, fw,fd, cw,cd, xst, xrv,xra, xill,xack, xrd,xrst,xrad
  localparam vec_t VEC [NV] = '{
    '{8'd9, 1'b0,2'd0,32'h0, 1'b0, 1'b1,1'b1,2'd3,S5,32'h100, 1'b0,4'h0, 1'b0,5'h0, RST, 1'b0,32'h0, 1'b0,1'b1, 1'b0,11'h0,32'h0},  // R9 write bank 3
    '{8'd9, 1'b0,2'd0,32'h0, 1'b0, 1'b1,1'b0,2'd3,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, RST, 1'b0,32'h0, 1'b0,1'b1, 1'b1,S5,32'h100}, // R9 read bank 3
    '{8'd4, 1'b0,2'd0,32'h0, 1'b1, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, S5, 1'b1,32'h100, 1'b0,1'b0, 1'b0,11'h0,32'h0},  // R4 return to level 0
    '{8'd6, 1'b0,2'd0,32'h0, 1'b1, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, S5, 1'b0,32'h0, 1'b1,1'b0, 1'b0,11'h0,32'h0},    // R6 return at level 0
    '{8'd8, 1'b0,2'd0,32'h0, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b1,5'h1F, S5, 1'b0,32'h0, 1'b1,1'b0, 1'b0,11'h0,32'h0},   // R8 mask write at level 0
    '{8'd9, 1'b0,2'd0,32'h0, 1'b0, 1'b1,1'b0,2'd1,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, S5, 1'b0,32'h0, 1'b1,1'b0, 1'b0,11'h0,32'h0},    // R9 read bank 1 at level 0
    '{8'd7, 1'b0,2'd0,32'h0, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b1,4'hA, 1'b0,5'h0, SA0, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0},   // R7 flags at level 0
    '{8'd5, 1'b1,2'd0,32'h999, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA0, 1'b0,32'h0, 1'b1,1'b0, 1'b0,11'h0,32'h0}, // R5 entry to level 0
    '{8'd2, 1'b1,2'd1,32'h200, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA1, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0}, // R2 entry to level 1
    '{8'd2, 1'b0,2'd0,32'h0, 1'b0, 1'b1,1'b0,2'd1,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA1, 1'b0,32'h0, 1'b0,1'b1, 1'b1,SA0,32'h200},  // R2 saved copy of level-0 status
    '{8'd8, 1'b0,2'd0,32'h0, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b1,5'h06, SA1C, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0}, // R8 mask write at level 1
    '{8'd7, 1'b0,2'd0,32'h0, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b1,4'h3, 1'b0,5'h0, S31C, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0},  // R7 flags at level 1
    '{8'd10, 1'b1,2'd2,32'h300, 1'b1, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, S32, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0}, // R10 entry beats return
    '{8'd5, 1'b1,2'd1,32'h888, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, S32, 1'b0,32'h0, 1'b1,1'b0, 1'b0,11'h0,32'h0},  // R5 entry to lower level
    '{8'd9, 1'b0,2'd0,32'h0, 1'b0, 1'b1,1'b0,2'd3,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, S32, 1'b0,32'h0, 1'b1,1'b0, 1'b0,11'h0,32'h0},    // R9 read bank 3 at level 2
    '{8'd11, 1'b0,2'd0,32'h0, 1'b1, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b1,4'hF, 1'b1,5'h00, S31C, 1'b1,32'h300, 1'b0,1'b0, 1'b0,11'h0,32'h0}, // R11 return drops writes
    '{8'd4, 1'b0,2'd0,32'h0, 1'b1, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA0, 1'b1,32'h200, 1'b0,1'b0, 1'b0,11'h0,32'h0},   // R4 return from level 1
    '{8'd11, 1'b1,2'd3,32'h400, 1'b0, 1'b1,1'b1,2'd3,11'h7FF,32'h555, 1'b0,4'h0, 1'b0,5'h0, SA3, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0}, // R11 entry drops access
    '{8'd3, 1'b0,2'd0,32'h0, 1'b0, 1'b1,1'b0,2'd3,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA3, 1'b0,32'h0, 1'b0,1'b1, 1'b1,SA0,32'h400},   // R3 address saved, access dropped
    '{8'd3, 1'b0,2'd0,32'h0, 1'b1, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA0, 1'b1,32'h400, 1'b0,1'b0, 1'b0,11'h0,32'h0},   // R3 return presents address
    '{8'd4, 1'b0,2'd0,32'h0, 1'b0, 1'b0,1'b0,2'd0,11'h0,32'h0, 1'b0,4'h0, 1'b0,5'h0, SA0, 1'b0,32'h0, 1'b0,1'b0, 1'b0,11'h0,32'h0}     // R4 pulse lasts one cycle
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string what, input int tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    entry_req = 0; entry_level = 0; entry_addr = 0; eret_req = 0;
    sr_req = 0; sr_we = 0; sr_lvl = 0; sr_wstatus = 0; sr_waddr = 0;
    flag_wr = 0; flag_data = 0; ctl_wr = 0; ctl_data = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("reset status", 1, status_o, RST);
    chk("reset ret_valid", 1, ret_valid_o, 0);
    chk("reset illegal", 1, illegal_o, 0);
    chk("reset ack", 1, sr_ack_o, 0);

    for (int i = 0; i < NV; i++) begin
      entry_req = VEC[i].en;  entry_level = VEC[i].elvl; entry_addr = VEC[i].eaddr;
      eret_req = VEC[i].er;
      sr_req = VEC[i].sq; sr_we = VEC[i].swe; sr_lvl = VEC[i].slvl;
      sr_wstatus = VEC[i].swst; sr_waddr = VEC[i].swad;
      flag_wr = VEC[i].fw; flag_data = VEC[i].fd;
      ctl_wr = VEC[i].cw; ctl_data = VEC[i].cd;
      @(negedge clk);
      chk($sformatf("v%0d status", i), VEC[i].tag, status_o, VEC[i].xst);
      chk($sformatf("v%0d ret_valid", i), VEC[i].tag, ret_valid_o, VEC[i].xrv);
      chk($sformatf("v%0d illegal", i), VEC[i].tag, illegal_o, VEC[i].xill);
      chk($sformatf("v%0d ack", i), VEC[i].tag, sr_ack_o, VEC[i].xack);
      if (VEC[i].xrv) chk($sformatf("v%0d ret_addr", i), VEC[i].tag, ret_addr_o, VEC[i].xra);
      if (VEC[i].xrd) begin
        chk($sformatf("v%0d rd status", i), VEC[i].tag, sr_rstatus_o, VEC[i].xrst);
        chk($sformatf("v%0d rd addr", i), VEC[i].tag, sr_raddr_o, VEC[i].xrad);
      end
    end

    // R1: reset in the same cycle as a legal return wins over it
    idle_inputs();
    entry_req = 1'b1; entry_level = 2'd1; entry_addr = 32'h600;
    @(negedge clk);
    chk("pre-reset entry", 2, status_o, SA1);
    entry_req = 1'b0;
    eret_req = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    eret_req = 1'b0;
    chk("reset mid-run status", 1, status_o, RST);
    chk("reset mid-run ret_valid", 1, ret_valid_o, 0);
    chk("reset mid-run illegal", 1, illegal_o, 0);

    // R9: bank level 0 is never accessible, even at level 3
    sr_req = 1'b1; sr_we = 1'b1; sr_lvl = 2'd0;
    @(negedge clk);
    idle_inputs();
    chk("bank 0 refused", 9, illegal_o, 1);
    chk("bank 0 no ack", 9, sr_ack_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule